// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat memory burst. A burst begins when either of two start strobes is high at a rising clock edge: the block captures the presented address and starts at beat zero. After that, the block makes each later address internally. It moves forward one beat on every edge where the advance input is high.

The two lowest address bits follow one of two orders, chosen by a static mode input. In linear order the start offset is incremented and wraps modulo four. In interleaved order the start offset is XORed with the beat number. The upper address bits keep the value captured at the start of the burst. The output is driven from registers through the order mapping only, so a new state appears at `addr_out` one clock after the edge that produced it.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the state clears. In the cycle after reset, `addr_out` is all zeros.
- R2: A high on `start_a` or on `start_b` at a rising edge captures `addr_in`. In the next cycle `addr_out` equals that captured value, in either order mode.
- R3: When a start strobe and `advance` are both high in one cycle, the start wins. The next address is the captured start address, not an advanced one.
- R4: With `order_sel` = 0 (linear), `addr_out[1:0]` equals (start offset + beats advanced) modulo 4. For example, start 2 gives 2,3,0,1.
- R5: With `order_sel` = 1 (interleaved), `addr_out[1:0]` equals start offset XOR beats advanced. For example, start 1 gives 1,0,3,2.
- R6: Between start strobes, `addr_out[ADDR_W-1:2]` keeps the upper bits of the captured start address.
- R7: On an edge with no start strobe and no `advance`, the address does not change.
- R8: The fourth advance after a start brings `addr_out` back to the captured start address. Later advances repeat the same four-address cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_a | input | 1 | First burst-start strobe, active high |
| start_b | input | 1 | Second burst-start strobe, active high |
| advance | input | 1 | Step to the next beat, active high |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Start address captured on a strobe |
| addr_out | output | ADDR_W | Current burst word address |

## Verification
The properties assume that `order_sel` is a strap. It may change only on an edge that also carries a start strobe, or during reset. If it changed in the middle of a burst, the output would move with no strobe and no advance. The stimulus therefore changes the mode only in the same cycle as a start strobe. The properties also assume the control inputs never carry unknown values. The bench drives every input from reset onward, so this holds. The interleaved step has no fixed relation to the previous address, so it is checked only by the cycle-by-cycle model.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Beat counter width: a burst covers 2**BEAT_W word locations.
    localparam int BEAT_W   = 2;
    localparam int BURST_LEN = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    // Per-cycle control decoded from the strobes.
    typedef struct packed {
        logic load;   // capture a new start address
        logic step;   // move to next beat
    } burst_ctl_t;

    function automatic beat_t linear_offset(beat_t start, beat_t beat);
        return beat_t'(start + beat);
    endfunction

    function automatic burst_ctl_t decode_ctl(logic sa, logic sb, logic adv);
        burst_ctl_t c;
        c.load = sa | sb;
        c.step = adv & ~(sa | sb);
        return c;
    endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [ADDR_W-1:0]        addr_in,
    output logic [ADDR_W-BEAT_W-1:0] base_hi,
    output beat_t                    base_lo
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [HI_W-1:0] hi_q;
    beat_t           lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (load) begin
            hi_q <= addr_in[ADDR_W-1:BEAT_W];
            lo_q <= addr_in[BEAT_W-1:0];
        end
    end

    assign base_hi = hi_q;
    assign base_lo = lo_q;

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  step,
    output beat_t beat
);
    beat_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= beat_t'(cnt_q + 1'b1);   // wraps after the last beat
        end
    end

    assign beat = cnt_q;

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
    import burst_pkg::*;
(
    input  beat_t  start,
    input  beat_t  beat,
    input  order_e order,
    output beat_t  offset
);
    beat_t ilv;
    beat_t lin;

    // Interleaved order: each offset bit is the start bit flipped by the beat bit.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
        assign ilv[b] = start[b] ^ beat[b];
    end

    assign lin = linear_offset(start, beat);

    always_comb begin
        unique case (order)
            ORDER_LINEAR:     offset = lin;
            ORDER_INTERLEAVE: offset = ilv;
            default:          offset = lin;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_a,
    input  logic              start_b,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    burst_ctl_t      ctl;
    logic [HI_W-1:0] base_hi;
    beat_t           base_lo;
    beat_t           beat;
    beat_t           offset;
    order_e          order;

    assign ctl   = decode_ctl(start_a, start_b, advance);
    assign order = order_e'(order_sel);

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.load),
        .addr_in (addr_in),
        .base_hi (base_hi),
        .base_lo (base_lo)
    );

    burst_beat_cnt u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (ctl.load),
        .step  (ctl.step),
        .beat  (beat)
    );

    burst_offset_map u_map (
        .start  (base_lo),
        .beat   (beat),
        .order  (order),
        .offset (offset)
    );

    assign addr_out = {base_hi, offset};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start_a,
    input logic              start_b,
    input logic              advance,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1: first cycle after reset shows zero address
    always @(negedge clk) begin
        if (rst_seen === 1'b1 && rst === 1'b0)
            assert_reset_zero_R1: assert (addr_out == '0);
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (start_a || start_b) |=> addr_out == $past(addr_in));

    assert_start_wins_R3: assert property (@(posedge clk) disable iff (rst)
        ((start_a || start_b) && advance) |=>
            addr_out[BEAT_W-1:0] == $past(addr_in[BEAT_W-1:0]));

    assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!start_a && !start_b && advance && !order_sel) ##1 !order_sel |->
            addr_out[BEAT_W-1:0] == beat_t'($past(addr_out[BEAT_W-1:0]) + 1'b1));

    assert_upper_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!start_a && !start_b) |=>
            addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!start_a && !start_b && !advance) ##1 $stable(order_sel) |->
            $stable(addr_out));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_a   (start_a),
    .start_b   (start_b),
    .advance   (advance),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .addr_out  (addr_out)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_a = 1'b0;
    logic          start_b = 1'b0;
    logic          advance = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    // Behavioural model state
    int m_base = 0;
    int m_beat = 0;

    always #10 clk = ~clk;   // 50 MHz

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .start_a(start_a), .start_b(start_b),
        .advance(advance), .order_sel(order_sel),
        .addr_in(addr_in), .addr_out(addr_out)
    );

    function automatic int expect_addr();
        int s = m_base % 4;
        int o = order_sel ? (s ^ m_beat) : ((s + m_beat) % 4);
        return (m_base / 4) * 4 + o;
    endfunction

    task automatic check(string req, int exp_v);
        total++;
        if (addr_out !== AW'(exp_v)) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, addr_out, AW'(exp_v));
        end
    endtask

    // Drive one cycle, update model at the edge, compare half a period later.
    task automatic step(input logic r, input logic sa, input logic sb,
                        input logic adv, input logic mode,
                        input int addr, input string req);
        rst = r; start_a = sa; start_b = sb; advance = adv;
        order_sel = mode; addr_in = AW'(addr);
        @(posedge clk);
        if (r) begin
            m_base = 0; m_beat = 0;
        end else if (sa || sb) begin
            m_base = addr; m_beat = 0;
        end else if (adv) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        check(req, expect_addr());
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int up;
        @(negedge clk);
        step(1, 0, 0, 0, 0, 0, "R1");
        step(1, 1, 0, 1, 0, 16'h1234, "R1");
        step(0, 0, 0, 0, 0, 16'h5555, "R1");
        check("R1", 0);

        // All four starts in both orders, four advances plus one extra (wrap)
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                up = (16'hA5C0 + m * 16'h0410 + s * 16'h0120) & 16'hFFFC;
                step(0, (s % 2) == 0, (s % 2) == 1, 0, m[0], up + s, "R2");
                for (int k = 1; k < 4; k++) begin
                    step(0, 0, 0, 1, m[0], 16'h0, m ? "R5" : "R4");
                    check("R6", up + (m ? (s ^ k) : ((s + k) % 4)));
                end
                step(0, 0, 0, 0, m[0], 16'hFFFF, "R7");
                step(0, 0, 0, 1, m[0], 16'h0, "R8");
                check("R8", up + s);
                step(0, 0, 0, 1, m[0], 16'h0, "R8");
            end
        end

        // Start strobe together with advance: start wins
        step(0, 1, 1, 1, 1, 16'h7E02, "R3");
        check("R3", 16'h7E02);
        step(0, 0, 1, 1, 0, 16'h0013, "R3");
        check("R3", 16'h0013);
        step(0, 0, 0, 1, 0, 16'h0, "R4");
        check("R4", 16'h0010);
        step(0, 0, 0, 0, 0, 16'h0, "R7");
        step(0, 0, 0, 0, 0, 16'hBEEF, "R7");
        check("R7", 16'h0010);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule